// File: doc/BRIEF.md
# DAC Power and Wake-Up Sequencer

This block decides when an analog DAC cell is powered. It watches a request-pending flag from the conversion queue. When the flag rises while the cell is idle, the block powers the cell up. It holds back conversions for a programmable number of start-up cycles, then raises a convert-enable output for as long as there is work. When the last queued conversion reports done and the queue is empty, the cell goes back to idle without any further command.

Two idle levels are available. With fast wake-up disabled, the idle level is a full power-down. With fast wake-up enabled, the idle level keeps the cell biased, and the next wake-up takes a quarter of the programmed start-up count. The two power outputs are separate, so the partial level can be seen from outside.

The sequencer has five states. OFF is fully unpowered. STANDBY is biased only and is used while fast wake-up is enabled. STARTUP is powered, with the start-up timer running. ACTIVE is powered, start-up is over and the cell is ready. CONVERT means a conversion is in progress. The transitions are named as follows. Wake (OFF or STANDBY to STARTUP) happens on a pending request. Settle (STARTUP to ACTIVE) happens when the timer runs out. Launch (ACTIVE to CONVERT) happens on a pending request. Abandon (ACTIVE to idle) happens when no request is pending. Retire (CONVERT to idle) happens on a done pulse with the queue empty. Park (OFF to STANDBY) and Release (STANDBY to OFF) follow the fast wake-up enable while no request is pending.

Top module: `dac_wake_seq`

## Requirements
- R1: During and right after reset the state is OFF, and pwr_on, bias_keep and conv_en are all 0.
- R2: A pending request seen in OFF or STANDBY moves the block to STARTUP on the next edge. In STARTUP, pwr_on=1, bias_keep=1 and conv_en=0.
- R3: A wake from OFF keeps the block in STARTUP for L = startup_cycles cycles, with a value of 0 treated as 1. After that, conv_en rises and the block is in ACTIVE.
- R4: Changes on req_pending during STARTUP neither restart nor extend the start-up count.
- R5: In ACTIVE with no request pending, the block goes on the next edge to STANDBY if fast_wake_en=1, and to OFF otherwise.
- R6: In CONVERT, conv_en stays 1 until a cycle in which conv_done=1 and req_pending=0. On that edge the block goes to the idle state that R5 selects.
- R7: A conv_done pulse in CONVERT while req_pending=1 keeps the block in CONVERT.
- R8: In OFF with no request and fast_wake_en=1, the block moves to STANDBY on the next edge. In STANDBY, pwr_on=0, bias_keep=1 and conv_en=0.
- R9: A wake from STANDBY lasts startup_cycles>>2 cycles in STARTUP, with a result of 0 treated as 1.
- R10: In STANDBY with no request and fast_wake_en=0, the block returns to OFF on the next edge.
- R11: conv_done has no effect in OFF, STANDBY or ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_pending | input | 1 | Conversion queue is not empty |
| conv_done | input | 1 | One-cycle pulse when a conversion finishes |
| startup_cycles | input | CNT_W | Full start-up time in clock cycles |
| fast_wake_en | input | 1 | Selects biased standby as the idle level |
| pwr_on | output | 1 | Full power to the analog cell |
| bias_keep | output | 1 | Bias kept on the analog cell |
| conv_en | output | 1 | Cell ready; conversions may proceed |

## Verification
The bench measures start-up lengths at the edge values of the count. A count of zero must give one cycle, and a fast count below four must also give one cycle. A design that let zero through would hang or skip start-up, and one that lost the floor on the shifted count would hang the same way. It drops and raises the request during start-up, which would catch a timer that reloads on a new request. It sends done pulses while the queue is still full and done pulses in the idle states. A design that keyed retirement on done alone would power down with work queued, and one that decoded done in every state would leave idle on its own. Long constrained-random runs then compare every output against a cycle model under all mixes of fast wake-up and the request pattern.

// File: rtl/dac_wake_pkg.sv
package dac_wake_pkg;

    typedef enum logic [2:0] {
        PS_OFF     = 3'd0,
        PS_STANDBY = 3'd1,
        PS_STARTUP = 3'd2,
        PS_ACTIVE  = 3'd3,
        PS_CONVERT = 3'd4
    } pwr_state_e;

endpackage

// File: rtl/dac_wake_timer.sv
module dac_wake_timer #(
    parameter int CNT_W   = 12,
    parameter int FAST_SH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             fast,
    input  logic [CNT_W-1:0] base,
    input  logic             run,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] scaled;
    logic [CNT_W-1:0] load_len;

    always_comb begin
        scaled   = fast ? (base >> FAST_SH) : base;
        load_len = (scaled == '0) ? ONE : scaled;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= ONE;
        end else if (load) begin
            cnt <= load_len;
        end else if (run && cnt > ONE) begin
            cnt <= cnt - ONE;
        end
    end

    assign last = (cnt <= ONE);

    // R4: a running count steps down by one and is never reloaded mid-run
    a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && run && cnt > ONE) |=> (cnt == CNT_W'($past(cnt) - ONE)));

    // R9: a freshly loaded length is never zero
    a_r9_len_floor: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt != '0));

endmodule

// File: rtl/dac_wake_fsm.sv
module dac_wake_fsm
    import dac_wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       done,
    input  logic       fast,
    input  logic       t_last,
    output pwr_state_e state,
    output logic       t_load,
    output logic       t_fast,
    output logic       t_run
);

    pwr_state_e nxt;
    pwr_state_e idle_tgt;

    assign idle_tgt = fast ? PS_STANDBY : PS_OFF;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PS_OFF;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt    = state;
        t_load = 1'b0;
        t_fast = 1'b0;
        t_run  = 1'b0;
        unique case (state)
            PS_OFF: begin
                if (req) begin
                    nxt    = PS_STARTUP;
                    t_load = 1'b1;
                end else if (fast) begin
                    nxt = PS_STANDBY;
                end
            end
            PS_STANDBY: begin
                if (req) begin
                    nxt    = PS_STARTUP;
                    t_load = 1'b1;
                    t_fast = 1'b1;
                end else if (!fast) begin
                    nxt = PS_OFF;
                end
            end
            PS_STARTUP: begin
                t_run = 1'b1;
                if (t_last) begin
                    nxt = PS_ACTIVE;
                end
            end
            PS_ACTIVE: begin
                nxt = req ? PS_CONVERT : idle_tgt;
            end
            PS_CONVERT: begin
                if (done && !req) begin
                    nxt = idle_tgt;
                end
            end
            default: nxt = PS_OFF;
        endcase
    end

    // R2: a pending request in either idle state wakes the cell
    a_r2_wake: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == PS_OFF || state == PS_STANDBY) && req) |=> (state == PS_STARTUP));

    // R3: start-up is left only when the timer reports its last cycle
    a_r3_hold_startup: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_STARTUP && !t_last) |=> (state == PS_STARTUP));

    // R6: a conversion is never abandoned without its done pulse
    a_r6_hold_convert: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_CONVERT && !done) |=> (state == PS_CONVERT));

    // R7: done with more work queued keeps converting
    a_r7_keep_going: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_CONVERT && done && req) |=> (state == PS_CONVERT));

    // R10: standby is released when fast wake-up is dropped
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_STANDBY && !req && !fast) |=> (state == PS_OFF));

endmodule

// File: rtl/dac_wake_outdec.sv
module dac_wake_outdec
    import dac_wake_pkg::*;
(
    input  pwr_state_e state,
    output logic       pwr_on,
    output logic       bias_keep,
    output logic       conv_en
);

    always_comb begin
        pwr_on    = 1'b0;
        bias_keep = 1'b0;
        conv_en   = 1'b0;
        unique case (state)
            PS_OFF: ;
            PS_STANDBY: bias_keep = 1'b1;
            PS_STARTUP: begin
                pwr_on    = 1'b1;
                bias_keep = 1'b1;
            end
            PS_ACTIVE, PS_CONVERT: begin
                pwr_on    = 1'b1;
                bias_keep = 1'b1;
                conv_en   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dac_wake_seq.sv
module dac_wake_seq
    import dac_wake_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_pending,
    input  logic             conv_done,
    input  logic [CNT_W-1:0] startup_cycles,
    input  logic             fast_wake_en,
    output logic             pwr_on,
    output logic             bias_keep,
    output logic             conv_en
);

    localparam int FAST_SH = 2;

    pwr_state_e state;
    logic       t_load;
    logic       t_fast;
    logic       t_run;
    logic       t_last;

    dac_wake_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req_pending),
        .done   (conv_done),
        .fast   (fast_wake_en),
        .t_last (t_last),
        .state  (state),
        .t_load (t_load),
        .t_fast (t_fast),
        .t_run  (t_run)
    );

    dac_wake_timer #(
        .CNT_W   (CNT_W),
        .FAST_SH (FAST_SH)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (t_load),
        .fast  (t_fast),
        .base  (startup_cycles),
        .run   (t_run),
        .last  (t_last)
    );

    dac_wake_outdec u_dec (
        .state     (state),
        .pwr_on    (pwr_on),
        .bias_keep (bias_keep),
        .conv_en   (conv_en)
    );

    // R8: full power always comes with bias
    a_r8_bias_under_power: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_on |-> bias_keep);

    // R5: ready with nothing queued drops power-ready on the next edge
    a_r5_abandon: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ACTIVE && !req_pending) |=> !conv_en);

    // R11: done pulses while idle leave the cell idle
    a_r11_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == PS_OFF || state == PS_STANDBY) && !req_pending && conv_done) |=> !pwr_on);

endmodule

// File: tb/dac_wake_seq_test.sv
module dac_wake_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_pending = 1'b0;
    logic             conv_done = 1'b0;
    logic [CNT_W-1:0] startup_cycles = '0;
    logic             fast_wake_en = 1'b0;
    logic             pwr_on;
    logic             bias_keep;
    logic             conv_en;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit finished = 1'b0;

    // bench model: 0 off, 1 standby, 2 startup, 3 active, 4 convert
    int m_st  = 0;
    int m_cnt = 0;

    dac_wake_seq #(.CNT_W(CNT_W)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_pending    (req_pending),
        .conv_done      (conv_done),
        .startup_cycles (startup_cycles),
        .fast_wake_en   (fast_wake_en),
        .pwr_on         (pwr_on),
        .bias_keep      (bias_keep),
        .conv_en        (conv_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int wake_len(int n, bit fast);
        int v;
        v = fast ? (n >> 2) : n;
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [2:0] exp_outs(int st);
        // {pwr_on, bias_keep, conv_en}
        case (st)
            1:       return 3'b010;
            2:       return 3'b110;
            3, 4:    return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    function automatic string st_tag(int st);
        case (st)
            1:       return "R8";
            2:       return "R3";
            3:       return "R5";
            4:       return "R6";
            default: return "R1";
        endcase
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st  <= 0;
            m_cnt <= 0;
        end else begin
            case (m_st)
                0: if (req_pending) begin
                       m_st <= 2; m_cnt <= wake_len(int'(startup_cycles), 1'b0);
                   end else if (fast_wake_en) m_st <= 1;
                1: if (req_pending) begin
                       m_st <= 2; m_cnt <= wake_len(int'(startup_cycles), 1'b1);
                   end else if (!fast_wake_en) m_st <= 0;
                2: if (m_cnt <= 1) m_st <= 3; else m_cnt <= m_cnt - 1;
                3: m_st <= req_pending ? 4 : (fast_wake_en ? 1 : 0);
                4: if (conv_done && !req_pending) m_st <= fast_wake_en ? 1 : 0;
                default: m_st <= 0;
            endcase
        end
    end

    // continuous comparison against the model on every falling edge
    always @(negedge clk) begin
        if (!finished) begin
            check({pwr_on, bias_keep, conv_en} == exp_outs(m_st), st_tag(m_st),
                  int'({pwr_on, bias_keep, conv_en}), int'(exp_outs(m_st)));
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!conv_en && n < 5000);
    endtask

    task automatic retire();
        req_pending = 1'b0;
        conv_done   = 1'b1;
        tick(1);
        conv_done   = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd7741));
        tick(2);
        check({pwr_on, bias_keep, conv_en} == 3'b000, "R1 in reset",
              int'({pwr_on, bias_keep, conv_en}), 0);
        rst_n = 1'b1;
        tick(2);
        check({pwr_on, bias_keep, conv_en} == 3'b000, "R1 after reset",
              int'({pwr_on, bias_keep, conv_en}), 0);

        // R2 and R3: full wake, N=10
        startup_cycles = 12'd10;
        req_pending = 1'b1;
        tick(1);
        check({pwr_on, bias_keep, conv_en} == 3'b110, "R2 startup outputs",
              int'({pwr_on, bias_keep, conv_en}), 6);
        measure(n);
        check(n == 10, "R3 full startup length", n + 1, 11);
        // R7: done with queue still full
        tick(2);
        conv_done = 1'b1;
        tick(1);
        conv_done = 1'b0;
        tick(1);
        check(conv_en == 1'b1, "R7 stays converting", int'(conv_en), 1);
        // R6: retire
        retire();
        check({pwr_on, conv_en} == 2'b00, "R6 retired to off",
              int'({pwr_on, conv_en}), 0);

        // R4: request wiggle during startup
        startup_cycles = 12'd8;
        req_pending = 1'b1;
        tick(3);
        req_pending = 1'b0;
        tick(1);
        req_pending = 1'b1;
        n = 0;
        while (!conv_en && n < 100) begin tick(1); n++; end
        check(n == 5, "R4 no restart", n, 5);
        tick(1);
        retire();

        // R3: zero count gives one cycle
        startup_cycles = 12'd0;
        req_pending = 1'b1;
        measure(n);
        check(n == 2, "R3 zero count floor", n, 2);
        retire();

        // R8: park in standby
        fast_wake_en = 1'b1;
        tick(1);
        check({pwr_on, bias_keep, conv_en} == 3'b010, "R8 standby outputs",
              int'({pwr_on, bias_keep, conv_en}), 2);
        // R11: done in standby ignored
        conv_done = 1'b1;
        tick(1);
        conv_done = 1'b0;
        tick(1);
        check({pwr_on, bias_keep, conv_en} == 3'b010, "R11 done in standby",
              int'({pwr_on, bias_keep, conv_en}), 2);
        // R9: fast wake, N=16 -> 4
        startup_cycles = 12'd16;
        req_pending = 1'b1;
        measure(n);
        check(n == 5, "R9 quarter startup", n, 5);
        retire();
        check({pwr_on, bias_keep} == 2'b01, "R6 retire to standby",
              int'({pwr_on, bias_keep}), 1);
        // R9: fast floor, N=3 -> 1
        startup_cycles = 12'd3;
        req_pending = 1'b1;
        measure(n);
        check(n == 2, "R9 quarter floor", n, 2);
        retire();

        // R10: release standby
        fast_wake_en = 1'b0;
        tick(1);
        check(bias_keep == 1'b0, "R10 back to off", int'(bias_keep), 0);
        // R11: done in off ignored
        conv_done = 1'b1;
        tick(1);
        conv_done = 1'b0;
        tick(1);
        check({pwr_on, bias_keep, conv_en} == 3'b000, "R11 done in off",
              int'({pwr_on, bias_keep, conv_en}), 0);

        // R5: request gone by end of startup
        startup_cycles = 12'd2;
        req_pending = 1'b1;
        tick(1);
        req_pending = 1'b0;
        tick(2);
        check(conv_en == 1'b1, "R5 active reached", int'(conv_en), 1);
        conv_done = 1'b1;
        tick(1);
        conv_done = 1'b0;
        check({pwr_on, conv_en} == 2'b00, "R5 R11 abandon to off",
              int'({pwr_on, conv_en}), 0);

        // constrained random, checked by the model every cycle
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 99) < 3) startup_cycles = CNT_W'($urandom_range(0, 24));
            if ($urandom_range(0, 99) < 2) fast_wake_en = ~fast_wake_en;
            if ($urandom_range(0, 99) < 12) req_pending = ~req_pending;
            conv_done = ($urandom_range(0, 99) < 20);
            tick(1);
        end
        req_pending = 1'b0;
        conv_done   = 1'b0;
        tick(40);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule